// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits beside a small 16-bit processor core and takes over the moments when control moves into or out of an interrupt handler. At every instruction boundary it looks at the pending requests and picks the most urgent one. The sources are a reset request, one non-maskable request and a parameterized group of maskable lines. If a request wins, the block stalls the core. It saves the return address and then the unmodified status word on the stack through a simple word-wide memory port. It then reads the handler address from a 32-slot vector table and loads the program counter, the cleared status word and the lowered stack pointer back into the core.

On a return strobe the block runs the reverse. It reads the saved status word from the stack, then the saved program counter, and then raises the stack pointer. The interrupt-enable and low-power state that held before entry is therefore restored exactly. A single-cycle acknowledge, which carries the slot number of the serviced source, lets a peripheral drop its request flag without software help.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `pc_load`, `sr_load`, `sp_load` and `ack_valid` are all 0.
- R2: Vector slot k (0..31) is the word at address VEC_BASE + 2k (default 0xFFC0). Reset uses slot 31. The non-maskable request uses slot 30. Maskable line i uses slot SLOT_OFS + i.
- R3: Priority runs reset first, then the non-maskable request, then maskable lines, where a higher line index wins.
- R4: Maskable lines are considered only while status bit 3 (global enable) of `sr_in` is 1. The non-maskable request is taken whatever bit 3 holds, including inside a maskable handler.
- R5: A maskable or non-maskable request is sampled only in a cycle with `insn_done` high. The entry begins in the next cycle. In that first cycle the block writes `pc_in` to SP-2. In the second cycle it writes the unmodified status word to SP-4.
- R6: In the third entry cycle the block reads the vector word. In that same cycle it asserts `pc_load` with that word, `sr_load` with the saved status with bits 3..7 cleared, `sp_load` with SP-4, and `ack_valid` with `ack_slot` set to the slot. `busy` is 0 in the cycle after.
- R7: A reset request is taken in any idle cycle, with no stack writes. In the next cycle the block reads 0xFFFE, loads PC, loads status 0 and leaves SP unloaded. It acknowledges slot 31.
- R8: A `reti_req` in an idle cycle starts a return. The first cycle reads address SP and loads it into status. The second cycle reads SP+2, loads it into PC and loads SP+4 into SP. If `reti_req` and `insn_done` arrive together, the return goes first.
- R9: After a return restores the global enable, the highest request still pending is serviced at the next boundary.
- R10: While `busy` is high, `insn_done`, `reti_req` and new requests have no effect on the sequence in progress.
- R11: With no eligible request at a boundary, the block stays idle and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_SRC | Maskable request lines |
| nmi_req | input | 1 | Non-maskable request |
| rst_req | input | 1 | Reset request |
| insn_done | input | 1 | Instruction-boundary strobe |
| reti_req | input | 1 | Return-from-interrupt strobe |
| sr_in | input | W | Current status word |
| pc_in | input | W | Current program counter |
| sp_in | input | W | Current stack pointer |
| busy | output | 1 | Sequence in progress; core must stall |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a word write |
| mem_addr | output | W | Byte address, word aligned |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, returned in the same cycle |
| pc_load | output | 1 | Load program counter |
| pc_value | output | W | New program counter |
| sr_load | output | 1 | Load status word |
| sr_value | output | W | New status word |
| sp_load | output | 1 | Load stack pointer |
| sp_value | output | W | New stack pointer |
| ack_valid | output | 1 | One-cycle entry acknowledge |
| ack_slot | output | 5 | Vector slot being serviced |

## Verification
The bench builds the block with eight maskable lines placed at slots 20 to 27. This leaves a gap below the fixed top two slots, so any mistake in mapping a line onto its slot shows up as a wrong vector address. It also means a random request vector often holds several lines at once, together with the non-maskable input. Every draw therefore exercises the ordering between the maskable group and the fixed slots. The stack sits in a small modelled window, and every entry is paired with a return, so the pop order and the pointer arithmetic are checked by restoring each saved register exactly.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   localparam int SLOT_W     = 5;
   localparam int NUM_SLOTS  = 1 << SLOT_W;
   localparam int RESET_SLOT = NUM_SLOTS - 1;
   localparam int NMI_SLOT   = NUM_SLOTS - 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_PC,
      ST_PUSH_SR,
      ST_VECTOR,
      ST_POP_SR,
      ST_POP_PC
   } seq_state_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
   import irq_seq_pkg::*;
#(
   parameter int NUM_SRC  = 8,
   parameter int SLOT_OFS = 16
) (
   input  logic [NUM_SRC-1:0] req_vec,
   input  logic               gie,
   input  logic               nmi,
   input  logic               rst,
   output logic               take,
   output logic [SLOT_W-1:0]  slot
);
   generate
      if (NUM_SRC < 1 || SLOT_OFS < 0 || SLOT_OFS + NUM_SRC > NMI_SLOT) begin : g_bad_map
         $error("maskable slots must lie below the non-maskable slot");
      end
   endgenerate

   // scan upward so the highest eligible line overwrites lower ones
   always_comb begin
      take = 1'b0;
      slot = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (req_vec[i] && gie) begin
            take = 1'b1;
            slot = SLOT_W'(SLOT_OFS + i);
         end
      end
      if (nmi) begin
         take = 1'b1;
         slot = SLOT_W'(NMI_SLOT);
      end
      if (rst) begin
         take = 1'b1;
         slot = SLOT_W'(RESET_SLOT);
      end
   end
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr
   import irq_seq_pkg::*;
#(
   parameter int          W        = 16,
   parameter logic [15:0] VEC_BASE = 16'hFFC0
) (
   input  logic [SLOT_W-1:0] slot,
   output logic [W-1:0]      addr
);
   localparam int SPAN = 2 * NUM_SLOTS;

   generate
      if (W < 8) begin : g_bad_width
         $error("data width too small for the vector table");
      end
      if ((int'(VEC_BASE) % SPAN) != 0) begin : g_bad_base
         $error("vector base must be aligned to the table span");
      end
   endgenerate

   assign addr = W'(VEC_BASE) + W'({slot, 1'b0});
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int          W           = 16,
   parameter int          NUM_SRC     = 8,
   parameter int          SLOT_OFS    = 16,
   parameter logic [15:0] VEC_BASE    = 16'hFFC0,
   parameter int          GIE_BIT     = 3,
   parameter logic [15:0] LOWPWR_MASK = 16'h00F0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               nmi_req,
   input  logic               rst_req,
   input  logic               insn_done,
   input  logic               reti_req,
   input  logic [W-1:0]       sr_in,
   input  logic [W-1:0]       pc_in,
   input  logic [W-1:0]       sp_in,
   output logic               busy,
   output logic               mem_req,
   output logic               mem_we,
   output logic [W-1:0]       mem_addr,
   output logic [W-1:0]       mem_wdata,
   input  logic [W-1:0]       mem_rdata,
   output logic               pc_load,
   output logic [W-1:0]       pc_value,
   output logic               sr_load,
   output logic [W-1:0]       sr_value,
   output logic               sp_load,
   output logic [W-1:0]       sp_value,
   output logic               ack_valid,
   output logic [SLOT_W-1:0]  ack_slot
);
   localparam logic [W-1:0] CLR_MASK = W'(LOWPWR_MASK) | (W'(1) << GIE_BIT);
   localparam logic [W-1:0] WORD     = W'(2);

   generate
      if (GIE_BIT < 0 || GIE_BIT >= W) begin : g_bad_gie
         $error("enable bit outside the status word");
      end
   endgenerate

   seq_state_e          state_q, state_d;
   logic [W-1:0]        pc_q, sr_q, sp_q;
   logic [SLOT_W-1:0]   slot_q;
   logic                win_take;
   logic [SLOT_W-1:0]   win_slot;
   logic [W-1:0]        vec_addr;
   logic                rst_win, start_entry;

   irq_pick #(.NUM_SRC(NUM_SRC), .SLOT_OFS(SLOT_OFS)) u_pick (
      .req_vec (irq_req),
      .gie     (sr_in[GIE_BIT]),
      .nmi     (nmi_req),
      .rst     (rst_req),
      .take    (win_take),
      .slot    (win_slot)
   );

   irq_vec_addr #(.W(W), .VEC_BASE(VEC_BASE)) u_vaddr (
      .slot (slot_q),
      .addr (vec_addr)
   );

   assign rst_win     = win_take && (win_slot == SLOT_W'(RESET_SLOT));
   assign start_entry = win_take && (insn_done || rst_win);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (reti_req)         state_d = ST_POP_SR;
            else if (start_entry) state_d = rst_win ? ST_VECTOR : ST_PUSH_PC;
         end
         ST_PUSH_PC: state_d = ST_PUSH_SR;
         ST_PUSH_SR: state_d = ST_VECTOR;
         ST_VECTOR:  state_d = ST_IDLE;
         ST_POP_SR:  state_d = ST_POP_PC;
         ST_POP_PC:  state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         sr_q    <= '0;
         sp_q    <= '0;
         slot_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && (reti_req || start_entry)) begin
            pc_q <= pc_in;
            sr_q <= sr_in;
            sp_q <= sp_in;
            if (!reti_req) slot_q <= win_slot;
         end
      end
   end

   always_comb begin
      busy      = (state_q != ST_IDLE);
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      pc_load   = 1'b0;
      pc_value  = mem_rdata;
      sr_load   = 1'b0;
      sr_value  = '0;
      sp_load   = 1'b0;
      sp_value  = '0;
      ack_valid = 1'b0;
      ack_slot  = slot_q;
      unique case (state_q)
         ST_PUSH_PC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - WORD;
            mem_wdata = pc_q;
         end
         ST_PUSH_SR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - 2 * WORD;
            mem_wdata = sr_q;
         end
         ST_VECTOR: begin
            mem_req   = 1'b1;
            mem_addr  = vec_addr;
            pc_load   = 1'b1;
            sr_load   = 1'b1;
            ack_valid = 1'b1;
            if (slot_q == SLOT_W'(RESET_SLOT)) begin
               sr_value = '0;
            end else begin
               sr_value = sr_q & ~CLR_MASK;
               sp_load  = 1'b1;
               sp_value = sp_q - 2 * WORD;
            end
         end
         ST_POP_SR: begin
            mem_req  = 1'b1;
            mem_addr = sp_q;
            sr_load  = 1'b1;
            sr_value = mem_rdata;
         end
         ST_POP_PC: begin
            mem_req  = 1'b1;
            mem_addr = sp_q + WORD;
            pc_load  = 1'b1;
            sp_load  = 1'b1;
            sp_value = sp_q + 2 * WORD;
         end
         default: ;
      endcase
   end

   // maskable slot acknowledged only if the captured status had the enable set
   assert_gie_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_slot < SLOT_W'(NMI_SLOT)) |-> sr_q[GIE_BIT]);

   // two back-to-back writes are followed by the vector cycle
   assert_push_then_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |=> (ack_valid && !mem_we));

   // a sequence only starts from a boundary, a return or a reset request
   assert_start_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(insn_done || reti_req || rst_req));

   // loading the program counter always ends the sequence
   assert_pc_load_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !busy);

   // the acknowledge lasts exactly one cycle
   assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> !ack_valid);

   // a reset entry never touches the stack pointer
   assert_reset_no_sp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_slot == SLOT_W'(RESET_SLOT)) |-> !sp_load && !$past(mem_we));
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
   localparam int SRC = 8;
   localparam int OFS = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SRC-1:0] irq_req = '0;
   logic nmi_req = 1'b0, rst_req = 1'b0, insn_done = 1'b0, reti_req = 1'b0;
   logic [15:0] sr_r = 16'h0000, pc_r = 16'h1000, sp_r = 16'h0240;
   logic busy, mem_req, mem_we, pc_load, sr_load, sp_load, ack_valid;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_value, sr_value, sp_value;
   logic [4:0] ack_slot;
   logic [15:0] stk [0:63];
   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   irq_entry_seq #(.W(16), .NUM_SRC(SRC), .SLOT_OFS(OFS)) dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
      .rst_req(rst_req), .insn_done(insn_done), .reti_req(reti_req),
      .sr_in(sr_r), .pc_in(pc_r), .sp_in(sp_r), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_load(pc_load),
      .pc_value(pc_value), .sr_load(sr_load), .sr_value(sr_value),
      .sp_load(sp_load), .sp_value(sp_value), .ack_valid(ack_valid),
      .ack_slot(ack_slot)
   );

   function automatic logic [15:0] vword(int k);
      return 16'hC000 | 16'(k << 4);
   endfunction

   function automatic int sidx(logic [15:0] a);
      logic [15:0] off;
      off = a - 16'h0200;
      return int'(off[6:1]);
   endfunction

   always_comb begin
      if (mem_addr >= 16'hFFC0) mem_rdata = vword(int'((mem_addr - 16'hFFC0) >> 1));
      else                      mem_rdata = stk[sidx(mem_addr)];
   end

   function automatic int exp_slot(logic [SRC-1:0] r, logic n, logic g);
      int s;
      s = -1;
      if (g) for (int i = 0; i < SRC; i++) if (r[i]) s = OFS + i;
      if (n) s = 30;
      return s;
   endfunction

   task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      logic [15:0] pv, sv, spv;
      pv = pc_value; sv = sr_value; spv = sp_value;
      if (mem_req && mem_we) stk[sidx(mem_addr)] = mem_wdata;
      if (pc_load) pc_r = pv;
      if (sr_load) sr_r = sv;
      if (sp_load) sp_r = spv;
      @(negedge clk);
   endtask

   logic [15:0] sv_pc, sv_sr, sv_sp;

   task automatic do_entry(int slot, string tag);
      sv_pc = pc_r; sv_sr = sr_r; sv_sp = sp_r;
      insn_done = 1'b1;
      cyc();
      chk(mem_we && mem_addr == sv_sp - 2 && mem_wdata == sv_pc,
          {tag, " R5 pc push"}, mem_wdata, sv_pc);
      cyc();
      chk(mem_we && mem_addr == sv_sp - 4 && mem_wdata == sv_sr,
          {tag, " R5 sr push unmodified"}, mem_wdata, sv_sr);
      cyc();
      insn_done = 1'b0;
      chk(!mem_we && mem_addr == 16'hFFC0 + 16'(2 * slot),
          {tag, " R2 vector addr"}, mem_addr, 16'hFFC0 + 16'(2 * slot));
      chk(pc_load && pc_value == vword(slot), {tag, " R6 pc"}, pc_value, vword(slot));
      chk(sr_load && sr_value == (sv_sr & 16'hFF07), {tag, " R6 sr cleared"},
          sr_value, sv_sr & 16'hFF07);
      chk(sp_load && sp_value == sv_sp - 4, {tag, " R6 sp"}, sp_value, sv_sp - 4);
      chk(ack_valid && ack_slot == 5'(slot), {tag, " R3 ack slot"}, 16'(ack_slot), 16'(slot));
      if (slot == 30) nmi_req = 1'b0;
      else irq_req[slot - OFS] = 1'b0;
      cyc();
      chk(!busy && !ack_valid, {tag, " R6 idle after"}, 16'(busy), 16'h0);
   endtask

   task automatic do_return(string tag);
      logic [15:0] e_sr, e_pc;
      e_sr = stk[sidx(sp_r)];
      e_pc = stk[sidx(sp_r + 2)];
      reti_req = 1'b1;
      cyc();
      reti_req = 1'b0;
      chk(mem_req && !mem_we && sr_load && sr_value == e_sr, {tag, " R8 pop sr"},
          sr_value, e_sr);
      cyc();
      chk(mem_addr == sp_r + 2 && pc_load && pc_value == e_pc, {tag, " R8 pop pc"},
          pc_value, e_pc);
      cyc();
      chk(pc_r == sv_pc && sr_r == sv_sr && sp_r == sv_sp, {tag, " R8 restored"},
          sr_r, sv_sr);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) stk[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_req && !pc_load && !sr_load && !sp_load && !ack_valid,
          "R1 reset idle", 16'(busy), 16'h0);

      // R11: requests pending but enable clear, nothing happens
      irq_req = 8'h11; sr_r = 16'h0000;
      insn_done = 1'b1;
      cyc(); cyc();
      insn_done = 1'b0;
      chk(!busy && !mem_req, "R11 R4 masked idle", 16'(mem_req), 16'h0);
      irq_req = '0;

      // R5: pending but no boundary strobe, nothing happens
      irq_req = 8'h01; sr_r = 16'h0008;
      cyc(); cyc();
      chk(!busy && !mem_req, "R5 no boundary", 16'(busy), 16'h0);

      // R9: two pending, highest first, the other after the return
      irq_req = 8'h24; sr_r = 16'h00F8; pc_r = 16'h2222; sp_r = 16'h0240;
      do_entry(OFS + 5, "R9 first");
      // R4: non-maskable taken inside the handler with the enable cleared
      nmi_req = 1'b1;
      begin
         logic [15:0] p1, s1, q1;
         p1 = sv_pc; s1 = sv_sr; q1 = sv_sp;
         do_entry(30, "R4 nmi nested");
         do_return("R4 nmi nested");
         sv_pc = p1; sv_sr = s1; sv_sp = q1;
      end
      do_return("R9 first");
      chk(sr_r[3] == 1'b1, "R9 enable restored", sr_r, 16'h00F8);
      do_entry(OFS + 2, "R9 second");
      do_return("R9 second");

      // R10: strobes during a sequence are ignored
      irq_req = 8'h80; sr_r = 16'h0008; pc_r = 16'h3000;
      sv_pc = pc_r; sv_sr = sr_r; sv_sp = sp_r;
      insn_done = 1'b1; cyc(); insn_done = 1'b0;
      reti_req = 1'b1; cyc(); reti_req = 1'b0;
      chk(mem_we && mem_wdata == sv_sr, "R10 sr push kept", mem_wdata, sv_sr);
      cyc();
      chk(ack_valid && ack_slot == 5'(OFS + 7), "R10 vector kept", 16'(ack_slot), 16'(OFS + 7));
      irq_req = '0;
      cyc();
      chk(!busy && !mem_req, "R10 no pop started", 16'(mem_req), 16'h0);
      do_return("R10 return");

      // R8: return wins over a simultaneous boundary
      irq_req = 8'h02; sr_r = 16'h0008; pc_r = 16'h4444;
      sv_pc = pc_r; sv_sr = sr_r; sv_sp = sp_r;
      insn_done = 1'b1; cyc(); insn_done = 1'b0; cyc(); cyc();
      irq_req = '0; cyc();
      irq_req = 8'h40;
      reti_req = 1'b1; insn_done = 1'b1; cyc(); reti_req = 1'b0; insn_done = 1'b0;
      chk(!mem_we && sr_load && mem_addr == sv_sp - 4, "R8 return first", mem_addr, sv_sp - 4);
      cyc(); cyc();
      irq_req = '0;

      // R7: reset request, no pushes, slot 31
      sr_r = 16'h00FF; sp_r = 16'h0230; pc_r = 16'h5555;
      rst_req = 1'b1; cyc(); rst_req = 1'b0;
      chk(!mem_we && mem_addr == 16'hFFFE && pc_value == vword(31), "R7 reset vector",
          pc_value, vword(31));
      chk(sr_load && sr_value == 16'h0 && !sp_load && ack_slot == 5'd31, "R7 reset status",
          sr_value, 16'h0);
      // R3: reset beats non-maskable and maskable
      cyc();
      nmi_req = 1'b1; irq_req = 8'hFF; sr_r = 16'h0008; rst_req = 1'b1; insn_done = 1'b1;
      cyc(); rst_req = 1'b0; insn_done = 1'b0;
      chk(ack_slot == 5'd31 && ack_valid, "R3 reset highest", 16'(ack_slot), 16'd31);
      cyc();
      nmi_req = 1'b0; irq_req = '0; sp_r = 16'h0240;

      // random mix
      void'($urandom(32'd11));
      for (int n = 0; n < 60; n++) begin
         int es;
         irq_req = SRC'($urandom);
         nmi_req = ($urandom % 4) == 0;
         sr_r = 16'($urandom) & 16'hFFF7;
         if ($urandom % 2) sr_r[3] = 1'b1;
         pc_r = 16'($urandom) & 16'hFFFE;
         sp_r = 16'h0230 + 16'(2 * ($urandom % 8));
         es = exp_slot(irq_req, nmi_req, sr_r[3]);
         if (es < 0) begin
            insn_done = 1'b1; cyc(); insn_done = 1'b0;
            chk(!busy && !mem_req, "R11 random idle", 16'(busy), 16'h0);
         end else begin
            do_entry(es, "R3 random");
            do_return("R8 random");
         end
         irq_req = '0; nmi_req = 1'b0;
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule